// File: doc/BRIEF.md
# Packed SIMD Shift Execution Unit

This execution unit shifts a 32-bit register operand as four independent byte lanes, two halfword lanes or one full word. A 5-bit sub-operation code chooses the lane width, the kind of shift and where the shift count comes from. The five kinds are plain left, saturating left, logical right, arithmetic right and rounding arithmetic right. The count comes either from the 5-bit immediate field or from the low bits of a second register value. Every lane is shifted by the same count, and the lanes go back into their original positions.

The unit sits in an execute stage. The decoder presents the sub-operation code, the immediate field, the destination index, both register values and two feature-enable levels, and raises a one-cycle valid strobe. One cycle later the unit returns the result with a write-enable, or it returns one of two exceptions instead. A sticky overflow flag collects left-shift overflows until reset.

Top module: `simd_shift_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, every output is zero, including `ovf_sticky`.
- R2: `out_valid` is high in exactly the cycle after an `in_valid` cycle. `wr_en`, `result` and both exceptions appear in that same cycle. Without `in_valid`, `out_valid` and `wr_en` stay low.
- R3: If `rd_idx` is 0, the operation is a no-op whatever the code or feature levels: no write, no exception, and `ovf_sticky` keeps its value.
- R4: Any `sub_op` outside the set listed in R7 to R11 raises `exc_reserved`, with no write. Examples are 0x10, 0x18 and 0x1F.
- R5: Codes 0x04, 0x05, 0x06, 0x07, 0x19 and 0x1B need `feat_rev2_en`. Every other legal code needs `feat_base_en`. A legal code whose required level is off raises `exc_feature`, with no write.
- R6: If `sub_op` bit 1 is 0, the count is `rs_field`. If it is 1, the count is `rs_value[4:0]` and the unused source is ignored. The count is masked to 3 bits for byte lanes, 4 bits for halfword lanes and 5 bits for the word.
- R7: Plain left shift, zero-filled per lane: byte 0x00/0x02, halfword 0x08/0x0A.
- R8: Saturating left shift: halfword 0x0C/0x0E, word 0x14/0x16. A lane that overflows is clamped to its most positive value if it was non-negative, or to its most negative value otherwise.
- R9: Logical right shift, zero-filled per lane: byte 0x01/0x03, halfword 0x19/0x1B.
- R10: Arithmetic right shift, sign-filled per lane: byte 0x04/0x06, halfword 0x09/0x0B.
- R11: Rounding arithmetic right: byte 0x05/0x07, halfword 0x0D/0x0F, word 0x15/0x17. For a count n > 0 the lane is sign-extended, 2^(n-1) is added and the sum is shifted right arithmetically by n. For n = 0 the lane is unchanged.
- R12: `ovf_sticky` is set when an executed left shift (R7 or R8) has any lane whose signed value times 2^n does not fit the lane. It is cleared only by reset, and right shifts never set it.
- R13: At most one of `wr_en`, `exc_reserved` and `exc_feature` is high in any cycle, and `result` is zero whenever `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| sub_op | input | 5 | Sub-operation code |
| rs_field | input | 5 | Immediate shift count |
| rd_idx | input | 5 | Destination register index |
| rs_value | input | 32 | Register holding the variable shift count |
| rt_value | input | 32 | Operand to be shifted |
| feat_base_en | input | 1 | Base feature level enabled |
| feat_rev2_en | input | 1 | Second feature revision enabled |
| out_valid | output | 1 | Response strobe, one cycle after `in_valid` |
| wr_en | output | 1 | Result should be written to `rd_idx` |
| result | output | 32 | Packed shifted lanes |
| exc_reserved | output | 1 | Reserved-instruction exception |
| exc_feature | output | 1 | Feature-unavailable exception |
| ovf_sticky | output | 1 | Sticky left-shift overflow flag |

## Verification
The checker watches, on every cycle, the one-cycle response timing, the exclusivity of the write and the two exceptions, the zero result on a non-write, and the sticky flag, which never falls and never moves on a no-op. It also checks three fixed encodings: the reserved-code exception, the revision gate on byte arithmetic right, and pass-through of word rounding at a zero count. Lane arithmetic can only be shown by the bench's sweeps, which cover every code, every count 0 to 31 and a set of edge operand patterns. Those sweeps exercise the count masking, saturation clamps, rounding carries, and the ignored count source under random noise.

// File: rtl/simd_shift_pkg.sv
// Shared types for the packed SIMD shift unit.
// Assumes a 5-bit sub-operation code and three lane widths.
package simd_shift_pkg;

    typedef enum logic [2:0] {
        SK_SLL,
        SK_SLL_SAT,
        SK_SRL,
        SK_SRA,
        SK_SRA_RND
    } shift_kind_e;

    typedef enum logic [1:0] {
        LW_BYTE,
        LW_HALF,
        LW_WORD
    } lane_width_e;

    typedef struct packed {
        logic        legal;
        logic        amt_from_reg;
        logic        needs_rev2;
        lane_width_e width;
        shift_kind_e kind;
    } shift_ctrl_t;

endpackage

// File: rtl/simd_shift_decode.sv
// Sub-operation decoder: maps the 5-bit code to lane width, shift kind,
// count source and required feature level. Unlisted codes are illegal.
module simd_shift_decode
    import simd_shift_pkg::*;
(
    input  logic [4:0]  sub_op,
    output shift_ctrl_t ctrl
);

    function automatic shift_ctrl_t mk(input logic from_reg, input logic rev2,
                                       input lane_width_e w, input shift_kind_e k);
        shift_ctrl_t c;
        c.legal        = 1'b1;
        c.amt_from_reg = from_reg;
        c.needs_rev2   = rev2;
        c.width        = w;
        c.kind         = k;
        return c;
    endfunction

    // Table decode of the sub-operation code
    always_comb begin
        ctrl = '{legal: 1'b0, amt_from_reg: 1'b0, needs_rev2: 1'b0,
                 width: LW_BYTE, kind: SK_SLL};
        case (sub_op)
            5'h00: ctrl = mk(1'b0, 1'b0, LW_BYTE, SK_SLL);
            5'h02: ctrl = mk(1'b1, 1'b0, LW_BYTE, SK_SLL);
            5'h01: ctrl = mk(1'b0, 1'b0, LW_BYTE, SK_SRL);
            5'h03: ctrl = mk(1'b1, 1'b0, LW_BYTE, SK_SRL);
            5'h04: ctrl = mk(1'b0, 1'b1, LW_BYTE, SK_SRA);
            5'h06: ctrl = mk(1'b1, 1'b1, LW_BYTE, SK_SRA);
            5'h05: ctrl = mk(1'b0, 1'b1, LW_BYTE, SK_SRA_RND);
            5'h07: ctrl = mk(1'b1, 1'b1, LW_BYTE, SK_SRA_RND);
            5'h08: ctrl = mk(1'b0, 1'b0, LW_HALF, SK_SLL);
            5'h0A: ctrl = mk(1'b1, 1'b0, LW_HALF, SK_SLL);
            5'h0C: ctrl = mk(1'b0, 1'b0, LW_HALF, SK_SLL_SAT);
            5'h0E: ctrl = mk(1'b1, 1'b0, LW_HALF, SK_SLL_SAT);
            5'h09: ctrl = mk(1'b0, 1'b0, LW_HALF, SK_SRA);
            5'h0B: ctrl = mk(1'b1, 1'b0, LW_HALF, SK_SRA);
            5'h0D: ctrl = mk(1'b0, 1'b0, LW_HALF, SK_SRA_RND);
            5'h0F: ctrl = mk(1'b1, 1'b0, LW_HALF, SK_SRA_RND);
            5'h19: ctrl = mk(1'b0, 1'b1, LW_HALF, SK_SRL);
            5'h1B: ctrl = mk(1'b1, 1'b1, LW_HALF, SK_SRL);
            5'h14: ctrl = mk(1'b0, 1'b0, LW_WORD, SK_SLL_SAT);
            5'h16: ctrl = mk(1'b1, 1'b0, LW_WORD, SK_SLL_SAT);
            5'h15: ctrl = mk(1'b0, 1'b0, LW_WORD, SK_SRA_RND);
            5'h17: ctrl = mk(1'b1, 1'b0, LW_WORD, SK_SRA_RND);
            default: ;
        endcase
    end

endmodule

// File: rtl/simd_shift_lane.sv
// One lane shifter of width LW. It computes all five shift kinds and picks one.
// Assumes the count is already masked to AW bits (count < LW).
module simd_shift_lane
    import simd_shift_pkg::*;
#(
    parameter int LW = 8,
    parameter int AW = $clog2(LW)
) (
    input  logic [LW-1:0] lane_in,
    input  logic [AW-1:0] amt,
    input  shift_kind_e   kind,
    output logic [LW-1:0] lane_out,
    output logic          lane_ovf
);

    localparam int WIDE = 2 * LW;

    logic            sign;
    logic [WIDE-1:0] wide_shl;
    logic [LW:0]     top_bits;
    logic            fits;
    logic [LW-1:0]   shl_val;
    logic [LW-1:0]   sat_val;
    logic [LW-1:0]   srl_val;
    logic [LW-1:0]   sra_val;
    logic [LW:0]     rnd_inc;
    logic [LW:0]     rnd_sum;
    logic [LW-1:0]   rnd_val;

    assign sign = lane_in[LW-1];

    // Left shift of the sign-extended lane; the upper bits reveal overflow
    assign wide_shl = {{LW{sign}}, lane_in} << amt;
    assign top_bits = wide_shl[WIDE-1:LW-1];
    assign fits     = (top_bits == '0) || (top_bits == '1);
    assign shl_val  = wide_shl[LW-1:0];
    assign sat_val  = sign ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};

    // Right shifts, zero-filled and sign-filled
    assign srl_val = lane_in >> amt;
    assign sra_val = LW'($signed(lane_in) >>> amt);

    // Rounding: add half of the last discarded weight, one extra bit of headroom
    assign rnd_inc = (amt == '0) ? '0 : ((LW+1)'(1) << (amt - AW'(1)));
    assign rnd_sum = {sign, lane_in} + rnd_inc;
    assign rnd_val = LW'($signed(rnd_sum) >>> amt);

    // Kind select and overflow report
    always_comb begin
        lane_ovf = 1'b0;
        case (kind)
            SK_SLL: begin
                lane_out = shl_val;
                lane_ovf = !fits;
            end
            SK_SLL_SAT: begin
                lane_out = fits ? shl_val : sat_val;
                lane_ovf = !fits;
            end
            SK_SRL:     lane_out = srl_val;
            SK_SRA:     lane_out = sra_val;
            SK_SRA_RND: lane_out = rnd_val;
            default:    lane_out = lane_in;
        endcase
    end

endmodule

// File: rtl/simd_shift_datapath.sv
// Lane-parallel datapath: byte, halfword and word lane sets run side by side
// on the same operand, and the decoded width picks one of them.
// Assumes DATA_W is a multiple of 2*BYTE_W and a power of two.
module simd_shift_datapath
    import simd_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amt_raw,
    input  lane_width_e       width,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] dp_result,
    output logic              dp_ovf
);

    localparam int HALF_W = 2 * BYTE_W;
    localparam int NUM_B  = DATA_W / BYTE_W;
    localparam int NUM_H  = DATA_W / HALF_W;
    localparam int B_AW   = $clog2(BYTE_W);
    localparam int H_AW   = $clog2(HALF_W);

    logic [DATA_W-1:0] byte_res, half_res, word_res;
    logic [NUM_B-1:0]  byte_ovf;
    logic [NUM_H-1:0]  half_ovf;
    logic              word_ovf;

    for (genvar g = 0; g < NUM_B; g++) begin : g_byte
        simd_shift_lane #(.LW(BYTE_W)) u_lane (
            .lane_in  (operand[g*BYTE_W +: BYTE_W]),
            .amt      (amt_raw[B_AW-1:0]),
            .kind     (kind),
            .lane_out (byte_res[g*BYTE_W +: BYTE_W]),
            .lane_ovf (byte_ovf[g])
        );
    end

    for (genvar g = 0; g < NUM_H; g++) begin : g_half
        simd_shift_lane #(.LW(HALF_W)) u_lane (
            .lane_in  (operand[g*HALF_W +: HALF_W]),
            .amt      (amt_raw[H_AW-1:0]),
            .kind     (kind),
            .lane_out (half_res[g*HALF_W +: HALF_W]),
            .lane_ovf (half_ovf[g])
        );
    end

    simd_shift_lane #(.LW(DATA_W)) u_word (
        .lane_in  (operand),
        .amt      (amt_raw),
        .kind     (kind),
        .lane_out (word_res),
        .lane_ovf (word_ovf)
    );

    // Width select of the packed result and the lane overflow summary
    always_comb begin
        case (width)
            LW_BYTE: begin
                dp_result = byte_res;
                dp_ovf    = |byte_ovf;
            end
            LW_HALF: begin
                dp_result = half_res;
                dp_ovf    = |half_ovf;
            end
            default: begin
                dp_result = word_res;
                dp_ovf    = word_ovf;
            end
        endcase
    end

endmodule

// File: rtl/simd_shift_unit.sv
// Packed SIMD shift execution unit (top). It decodes the sub-operation, picks
// the count source, runs the lane datapath and registers the response one
// cycle after in_valid. Assumes IDX_W >= $clog2(DATA_W).
module simd_shift_unit
    import simd_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int OP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   sub_op,
    input  logic [IDX_W-1:0]  rs_field,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rs_value,
    input  logic [DATA_W-1:0] rt_value,
    input  logic              feat_base_en,
    input  logic              feat_rev2_en,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              exc_reserved,
    output logic              exc_feature,
    output logic              ovf_sticky
);

    localparam int AMT_W = $clog2(DATA_W);

    shift_ctrl_t       ctrl;
    logic [AMT_W-1:0]  amt_raw;
    logic [DATA_W-1:0] dp_result;
    logic              dp_ovf;
    logic              rd_nz;
    logic              feat_ok;
    logic              do_write;
    logic              unused_rs_hi;

    simd_shift_decode u_dec (
        .sub_op (sub_op),
        .ctrl   (ctrl)
    );

    // Count source: immediate field or low bits of the register value
    assign amt_raw      = ctrl.amt_from_reg ? rs_value[AMT_W-1:0] : rs_field[AMT_W-1:0];
    assign unused_rs_hi = ^{rs_value[DATA_W-1:AMT_W], rs_field};

    simd_shift_datapath #(.DATA_W(DATA_W)) u_dp (
        .operand   (rt_value),
        .amt_raw   (amt_raw),
        .width     (ctrl.width),
        .kind      (ctrl.kind),
        .dp_result (dp_result),
        .dp_ovf    (dp_ovf)
    );

    // Gating: no-op destination, legality, then feature level
    assign rd_nz    = |rd_idx;
    assign feat_ok  = ctrl.needs_rev2 ? feat_rev2_en : feat_base_en;
    assign do_write = rd_nz && ctrl.legal && feat_ok;

    // Response register and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            wr_en        <= 1'b0;
            result       <= '0;
            exc_reserved <= 1'b0;
            exc_feature  <= 1'b0;
            ovf_sticky   <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            wr_en        <= in_valid && do_write;
            result       <= (in_valid && do_write) ? dp_result : '0;
            exc_reserved <= in_valid && rd_nz && !ctrl.legal;
            exc_feature  <= in_valid && rd_nz && ctrl.legal && !feat_ok;
            if (in_valid && do_write && dp_ovf) begin
                ovf_sticky <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/simd_shift_unit_chk.sv
// Property checker for simd_shift_unit, attached by bind. Observes ports only.
module simd_shift_unit_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int OP_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   sub_op,
    input logic [IDX_W-1:0]  rs_field,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [DATA_W-1:0] rt_value,
    input logic              feat_base_en,
    input logic              feat_rev2_en,
    input logic              out_valid,
    input logic              wr_en,
    input logic [DATA_W-1:0] result,
    input logic              exc_reserved,
    input logic              exc_feature,
    input logic              ovf_sticky
);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en));

    p_nop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_idx == '0) |=> (!wr_en && !exc_reserved && !exc_feature));

    p_nop_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_idx == '0) |=> (ovf_sticky == $past(ovf_sticky)));

    p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_idx != '0 && sub_op == 5'h1F) |=> (exc_reserved && !wr_en));

    p_rev2_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_idx != '0 && sub_op == 5'h04 && !feat_rev2_en) |=> exc_feature);

    p_rnd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_idx != '0 && sub_op == 5'h15 && rs_field == '0 && feat_base_en)
        |=> (wr_en && result == $past(rt_value)));

    p_sticky_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

    p_right_no_ovf_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sub_op == 5'h01 && !ovf_sticky) |=> !ovf_sticky);

    p_exclusive_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, exc_reserved, exc_feature}));

    p_zero_result_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (result == '0));

endmodule

bind simd_shift_unit simd_shift_unit_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .OP_W   (OP_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .sub_op       (sub_op),
    .rs_field     (rs_field),
    .rd_idx       (rd_idx),
    .rt_value     (rt_value),
    .feat_base_en (feat_base_en),
    .feat_rev2_en (feat_rev2_en),
    .out_valid    (out_valid),
    .wr_en        (wr_en),
    .result       (result),
    .exc_reserved (exc_reserved),
    .exc_feature  (exc_feature),
    .ovf_sticky   (ovf_sticky)
);

// File: tb/simd_shift_unit_tb_top.sv
// Sweep bench: every code, every count 0..31 and edge operand patterns.
// Expected values come from arithmetic on signed lane values.
module simd_shift_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  sub_op = '0;
    logic [4:0]  rs_field = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rs_value = '0;
    logic [31:0] rt_value = '0;
    logic        feat_base_en = 1'b0;
    logic        feat_rev2_en = 1'b0;
    logic        out_valid, wr_en, exc_reserved, exc_feature, ovf_sticky;
    logic [31:0] result;

    int          nvec = 0;
    int          nfail = 0;
    bit          exp_ovf = 1'b0;
    logic [31:0] rng = 32'h1234_abcd;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    simd_shift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
        .rs_field(rs_field), .rd_idx(rd_idx), .rs_value(rs_value),
        .rt_value(rt_value), .feat_base_en(feat_base_en),
        .feat_rev2_en(feat_rev2_en), .out_valid(out_valid), .wr_en(wr_en),
        .result(result), .exc_reserved(exc_reserved),
        .exc_feature(exc_feature), .ovf_sticky(ovf_sticky)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] pattern(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7F7F_7F7F;
            3: return 32'h8080_8080;
            4: return 32'h1234_5678;
            5: return 32'hC3A5_5A3C;
            6: return 32'h00FF_7F80;
            default: return 32'h4001_8000;
        endcase
    endfunction

    // Encoding table from R4..R11: width 0 = reserved; kind 0 sll,1 sat,2 srl,3 sra,4 rnd
    task automatic ref_decode(input logic [4:0] op, output int w, output int k,
                              output bit rf, output bit n2);
        w = 0; k = 0; rf = op[1]; n2 = 1'b0;
        case (op)
            5'h00, 5'h02: begin w = 8;  k = 0; end
            5'h01, 5'h03: begin w = 8;  k = 2; end
            5'h04, 5'h06: begin w = 8;  k = 3; n2 = 1'b1; end
            5'h05, 5'h07: begin w = 8;  k = 4; n2 = 1'b1; end
            5'h08, 5'h0A: begin w = 16; k = 0; end
            5'h0C, 5'h0E: begin w = 16; k = 1; end
            5'h09, 5'h0B: begin w = 16; k = 3; end
            5'h0D, 5'h0F: begin w = 16; k = 4; end
            5'h19, 5'h1B: begin w = 16; k = 2; n2 = 1'b1; end
            5'h14, 5'h16: begin w = 32; k = 1; end
            5'h15, 5'h17: begin w = 32; k = 4; end
            default: w = 0;
        endcase
    endtask

    task automatic ref_lane(input longint v, input int w, input int n, input int k,
                            output longint r, output bit ovf);
        longint lim  = longint'(1) << w;
        longint half = longint'(1) << (w - 1);
        longint s    = (v >= half) ? v - lim : v;
        longint big;
        ovf = 1'b0;
        case (k)
            0, 1: begin
                big = s * (longint'(1) << n);
                ovf = (big > half - 1) || (big < -half);
                if (k == 1 && ovf) r = (s < 0) ? -half : half - 1;
                else r = big;
            end
            2: r = v >> n;
            3: r = s >>> n;
            default: r = (n == 0) ? s : ((s + (longint'(1) << (n - 1))) >>> n);
        endcase
        r = r & (lim - 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_ovf = 1'b0;
        nvec++;
        if (out_valid || wr_en || result != 0 || exc_reserved || exc_feature || ovf_sticky) begin
            nfail++;
            $display("FAIL R1 reset state: got v=%0b w=%0b r=%h x=%0b f=%0b o=%0b exp all zero",
                     out_valid, wr_en, result, exc_reserved, exc_feature, ovf_sticky);
        end
    endtask

    task automatic apply(input logic [4:0] op, input int amt, input logic [4:0] rd,
                         input logic [31:0] rtv, input bit base, input bit rev2);
        int w, k, n, cnt;
        bit rf, n2, lo, bad;
        longint r;
        logic [31:0] rsv, exp_res;
        logic [4:0] rsf;
        bit exp_wr, exp_rx, exp_fx;
        string tag, tag2;
        ref_decode(op, w, k, rf, n2);
        rng = next_rng(rng);
        // R6: the unused count source carries noise
        if (rf) begin
            rsv = {rng[31:5], 5'(amt)};
            rsf = rng[4:0];
        end else begin
            rsv = rng;
            rsf = 5'(amt);
        end
        cnt = amt;
        exp_wr = 0; exp_rx = 0; exp_fx = 0; exp_res = '0;
        tag2 = "";
        if (rd == 0) tag = "R3";
        else if (w == 0) begin tag = "R4"; exp_rx = 1; end
        else if (!(n2 ? rev2 : base)) begin tag = "R5"; exp_fx = 1; end
        else begin
            exp_wr = 1;
            n = cnt & (w - 1);
            if (cnt > w - 1) tag2 = "+R6";
            case (k)
                0: tag = "R7";
                1: tag = "R8";
                2: tag = "R9";
                3: tag = "R10";
                default: tag = "R11";
            endcase
            for (int l = 0; l < 32 / w; l++) begin
                ref_lane((longint'(rtv) >> (l * w)) & ((longint'(1) << w) - 1), w, n, k, r, lo);
                exp_res = exp_res | (32'(r) << (l * w));
                if (lo && k <= 1) exp_ovf = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b1; sub_op = op; rs_field = rsf; rd_idx = rd;
        rs_value = rsv; rt_value = rtv; feat_base_en = base; feat_rev2_en = rev2;
        @(negedge clk);
        in_valid = 1'b0;
        nvec++;
        bad = (wr_en != exp_wr) || (exc_reserved != exp_rx) || (exc_feature != exp_fx) ||
              (result != exp_res) || !out_valid;
        if (ovf_sticky != exp_ovf) begin
            nfail++;
            $display("FAIL R12 op=%h amt=%0d rt=%h: got ovf=%0b exp %0b",
                     op, amt, rtv, ovf_sticky, exp_ovf);
        end else if (bad) begin
            nfail++;
            $display("FAIL %s%s (R2/R13) op=%h amt=%0d rd=%0d rt=%h: got v=%0b w=%0b x=%0b f=%0b r=%h exp v=1 w=%0b x=%0b f=%0b r=%h",
                     tag, tag2, op, amt, rd, rtv, out_valid, wr_en, exc_reserved, exc_feature,
                     result, exp_wr, exp_rx, exp_fx, exp_res);
        end
        @(negedge clk);
        nvec++;
        if (out_valid || wr_en) begin
            nfail++;
            $display("FAIL R2 idle after op=%h: got v=%0b w=%0b exp 0 0", op, out_valid, wr_en);
        end
    endtask

    initial begin
        do_reset();
        // Main sweep: every code, count, operand pattern; reset per code for R12
        for (int op = 0; op < 32; op++) begin
            do_reset();
            for (int amt = 0; amt < 32; amt++) begin
                for (int p = 0; p < 8; p++) begin
                    rng = next_rng(rng);
                    apply(5'(op), amt, 5'(1 + (rng % 31)), pattern(p), 1'b1, 1'b1);
                end
            end
        end
        // R5 feature gate: all codes under all four enable combinations
        do_reset();
        for (int op = 0; op < 32; op++) begin
            for (int fe = 0; fe < 4; fe++) begin
                apply(5'(op), 1, 5'd5, 32'h1234_5678, fe[0], fe[1]);
            end
        end
        // R3 no-op: overflow-prone operand with rd 0 must leave everything quiet
        do_reset();
        for (int op = 0; op < 32; op++) begin
            for (int fe = 0; fe < 4; fe++) begin
                apply(5'(op), 3, 5'd0, 32'h7F7F_7F7F, fe[0], fe[1]);
            end
        end
        do_reset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    // Watchdog: a hang counts as a failed check
    initial begin
        #(4 * 190000);
        if (!done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog expired: got hang, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule